// File: doc/BRIEF.md
# Deferred Read-Based Refresh Scheduler

This block keeps the contents of one DRAM bank group alive without ever using the device's dedicated refresh command. Instead, it walks a row pointer through every row of the group. It refreshes one row at a time by placing an ordinary row read into one of the group's access slots. A read of this kind is short, so a client request waiting behind it is held up far less than it would be by a full refresh command.

A free-running interval timer raises a refresh obligation once per interval. The interval is chosen a little shorter than retention strictly needs. The obligation is not served while the group is in the middle of a multi-slot transaction. It waits until the transaction has ended and is then served in the first slot offered, ahead of any new client request. The slack left by the shortened interval absorbs this delay, so every row is still read again inside its retention window. Elaboration rejects any parameter set in which the full sweep period plus the allowed deferral does not fit in the retention budget.

The scheduler that owns the group's time slots drives `txn_busy` and `slot_open`. This block answers in the same cycle with either a refresh read (`rfr_fire` with `rfr_row`) or a grant for the waiting client request.

Top module: `deferred_refresh_sched`

## Requirements
- R1: While reset is asserted and directly after it is released, `rfr_fire` is 0 and `rfr_row` is 0. With no refresh owed, a client request in an open, idle slot is granted.
- R2: After reset the first refresh becomes owed INTERVAL cycles after release. With slots always open and no transaction, refresh reads are then issued exactly INTERVAL cycles apart.
- R3: Each issued refresh read advances `rfr_row` by one in the following cycle. The row after ROWS-1 is 0.
- R4: No refresh read is issued in any cycle in which `txn_busy` is 1.
- R5: A refresh that falls due during a transaction is issued in the first cycle in which `slot_open` is 1 and `txn_busy` is 0.
- R6: In a cycle where a refresh is issued, `client_grant` is 0 even if `client_req` is 1. Otherwise `client_grant` equals `client_req` AND `slot_open` AND NOT `txn_busy`.
- R7: No refresh read is issued in a cycle in which `slot_open` is 0.
- R8: At most one refresh is held owed. If several intervals elapse while refresh is blocked, a single read is issued when the block lifts, and the next read comes at the next interval expiry.
- R9: A refresh never waits more than MAX_DEFER cycles once owed. The cycles between two reads of the same row never exceed ROWS × INTERVAL + MAX_DEFER.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_busy | input | 1 | Group is inside a multi-slot transaction |
| slot_open | input | 1 | The group's access slot is available this cycle |
| client_req | input | 1 | A new client request wants this slot |
| rfr_fire | output | 1 | Issue a refresh read in this slot |
| rfr_row | output | RW | Row to read for refresh (RW = clog2 ROWS) |
| client_grant | output | 1 | The client request takes this slot |

## Verification
The hardest state to reach is a refresh that has been owed across more than one interval expiry while blocked. From that state, exactly one read must follow and the next read must land on the following expiry rather than straight away. The stimulus holds `slot_open` low for slightly more than two intervals after reset, then opens it and counts cycles to the next read. A second hard point is the row-revisit bound under real interference. A long run with periodic transactions and every-other-cycle slots records, for each row, the cycle of each read and compares the gaps against the bound.

// File: rtl/rfr_pkg.sv
package rfr_pkg;

   // Width of a counter that must hold values 0 .. n-1.
   function automatic int unsigned cnt_w(input longint unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // True when n is a power of two (used to pick a wrap variant).
   function automatic bit is_pow2(input longint unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/rfr_interval_timer.sv
module rfr_interval_timer
   import rfr_pkg::*;
#(
   parameter int unsigned INTERVAL = 1560
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CW = cnt_w(INTERVAL);
   localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

   logic [CW-1:0] cnt_q;

   assign tick = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   // Counter stays inside 0 .. INTERVAL-1 (R2)
   p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // After an expiry the count restarts from zero (R2)
   p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt_q == '0));
endmodule

// File: rtl/rfr_row_counter.sv
module rfr_row_counter
   import rfr_pkg::*;
#(
   parameter int unsigned ROWS = 8192,
   parameter int unsigned RW   = cnt_w(ROWS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [RW-1:0] row
);
   localparam logic [RW-1:0] TOP = RW'(ROWS - 1);

   logic [RW-1:0] row_q;
   logic [RW-1:0] row_nx;

   generate
      if (is_pow2(ROWS)) begin : g_wrap_free
         assign row_nx = row_q + 1'b1;
      end else begin : g_wrap_cmp
         assign row_nx = (row_q == TOP) ? '0 : row_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         row_q <= '0;
      else if (adv)
         row_q <= row_nx;
   end

   assign row = row_q;

   // A fired refresh moves the pointer one row on, wrapping at the top (R3)
   p_row_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (row_q == (($past(row_q) == TOP) ? '0 : $past(row_q) + 1'b1)));

   // The pointer holds when no refresh was fired (R3)
   p_row_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(row_q));

   p_row_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      row_q <= TOP);
endmodule

// File: rtl/rfr_slot_arbiter.sv
module rfr_slot_arbiter
   import rfr_pkg::*;
#(
   parameter int unsigned MAX_DEFER = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic txn_busy,
   input  logic slot_open,
   input  logic client_req,
   output logic fire,
   output logic client_grant
);
   localparam int unsigned AW = cnt_w(MAX_DEFER + 2);
   localparam logic [AW-1:0] AGE_LIM = AW'(MAX_DEFER);
   localparam logic [AW-1:0] AGE_SAT = AW'(MAX_DEFER + 1);

   logic owed_q;
   logic slot_free;

   assign slot_free    = slot_open & ~txn_busy;
   assign fire         = owed_q & slot_free;
   assign client_grant = client_req & slot_free & ~fire;

   // Single owed flag: a fresh expiry re-arms it even in the firing cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         owed_q <= 1'b0;
      else if (tick)
         owed_q <= 1'b1;
      else if (fire)
         owed_q <= 1'b0;
   end

   // Age of the owed refresh, kept for the deferral bound check
   logic [AW-1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         age_q <= '0;
      else if (fire || !owed_q)
         age_q <= '0;
      else if (age_q != AGE_SAT)
         age_q <= age_q + 1'b1;
   end

   p_defer_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      age_q <= AGE_LIM);

   p_no_fire_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      txn_busy |-> !fire);

   p_fire_needs_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> slot_open);

   p_refresh_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(fire && client_grant));

   p_owed_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> owed_q);

   // Without a new expiry, a fired refresh leaves nothing owed (R8)
   p_single_owed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !tick) |=> !owed_q);
endmodule

// File: rtl/deferred_refresh_sched.sv
module deferred_refresh_sched
   import rfr_pkg::*;
#(
   parameter int unsigned ROWS       = 8192,
   parameter int unsigned INTERVAL   = 1560,
   parameter int unsigned MAX_DEFER  = 64,
   parameter longint unsigned RETAIN = 64'd12_800_000,
   parameter int unsigned RW         = cnt_w(ROWS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          txn_busy,
   input  logic          slot_open,
   input  logic          client_req,
   output logic          rfr_fire,
   output logic [RW-1:0] rfr_row,
   output logic          client_grant
);
   localparam longint unsigned SWEEP = longint'(ROWS) * longint'(INTERVAL);
   localparam longint unsigned WORST = SWEEP + longint'(MAX_DEFER);

   generate
      if (ROWS < 2) begin : g_bad_rows
         $error("deferred_refresh_sched: ROWS must be at least 2");
      end
      if (INTERVAL < 2) begin : g_bad_interval
         $error("deferred_refresh_sched: INTERVAL must be at least 2");
      end
      if (RW < cnt_w(ROWS)) begin : g_bad_rw
         $error("deferred_refresh_sched: RW too narrow for ROWS");
      end
      if (WORST > RETAIN) begin : g_no_slack
         $error("deferred_refresh_sched: sweep plus deferral exceeds retention");
      end
   endgenerate

   logic tick;

   rfr_interval_timer #(
      .INTERVAL (INTERVAL)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   rfr_slot_arbiter #(
      .MAX_DEFER (MAX_DEFER)
   ) u_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .txn_busy     (txn_busy),
      .slot_open    (slot_open),
      .client_req   (client_req),
      .fire         (rfr_fire),
      .client_grant (client_grant)
   );

   rfr_row_counter #(
      .ROWS (ROWS),
      .RW   (RW)
   ) u_rows (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (rfr_fire),
      .row   (rfr_row)
   );

   // Port-level view: a busy group never sees a refresh read (R4)
   p_top_quiet_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      txn_busy |-> !rfr_fire);
endmodule

// File: tb/deferred_refresh_sched_bench.sv
module deferred_refresh_sched_bench;
   localparam int unsigned ROWS  = 8;
   localparam int unsigned IVL   = 16;
   localparam int unsigned MAXD  = 40;
   localparam int unsigned RW    = 3;
   localparam int          BOUND = ROWS * IVL + MAXD;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          txn_busy = 1'b0;
   logic          slot_open = 1'b0;
   logic          client_req = 1'b0;
   logic          rfr_fire;
   logic [RW-1:0] rfr_row;
   logic          client_grant;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #4 clk = ~clk;

   deferred_refresh_sched #(
      .ROWS      (ROWS),
      .INTERVAL  (IVL),
      .MAX_DEFER (MAXD),
      .RETAIN    (64'(BOUND)),
      .RW        (RW)
   ) u_deferred_refresh_sched (
      .clk          (clk),
      .rst_n        (rst_n),
      .txn_busy     (txn_busy),
      .slot_open    (slot_open),
      .client_req   (client_req),
      .rfr_fire     (rfr_fire),
      .rfr_row      (rfr_row),
      .client_grant (client_grant)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; txn_busy = 0; slot_open = 0; client_req = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc = 0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      cyc++;
   endtask

   // R1: reset state and grant with nothing owed
   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0; slot_open = 1; client_req = 1;
      repeat (2) @(negedge clk);
      #1;
      check(rfr_fire == 0, "R1 fire in reset", int'(rfr_fire), 0);
      check(rfr_row == 0, "R1 row in reset", int'(rfr_row), 0);
      @(negedge clk);
      rst_n = 1'b1;
      cyc = 0;
      step();
      #1;
      check(rfr_fire == 0, "R1 fire after release", int'(rfr_fire), 0);
      check(client_grant == 1, "R1 grant idle", int'(client_grant), 1);
   endtask

   // R2/R3: periodic issue and row walk with wrap
   task automatic t_period();
      int first, prev, seen;
      first = -1; prev = -1; seen = 0;
      do_reset();
      slot_open = 1;
      for (int k = 0; k <= 10 * IVL; k++) begin
         #1;
         if (rfr_fire) begin
            if (first < 0) begin
               first = cyc;
               check(cyc == IVL, "R2 first refresh", cyc, IVL);
            end else begin
               check(cyc - prev == IVL, "R2 spacing", cyc - prev, IVL);
            end
            check(int'(rfr_row) == (seen % ROWS), "R3 row order", int'(rfr_row), seen % ROWS);
            prev = cyc;
            seen++;
         end
         step();
      end
      check(seen == 10, "R2 refresh count", seen, 10);
   endtask

   // R4/R5/R7: hold off while busy and while no slot, then fire at once
   task automatic t_busy();
      bit any;
      do_reset();
      txn_busy = 1; slot_open = 1;
      any = 0;
      for (int k = 0; k <= IVL + 5; k++) begin
         #1;
         if (rfr_fire) any = 1;
         step();
      end
      check(!any, "R4 no refresh while busy", int'(any), 0);
      txn_busy = 0; slot_open = 0;
      any = 0;
      for (int k = 0; k < 3; k++) begin
         #1;
         if (rfr_fire) any = 1;
         step();
      end
      check(!any, "R7 no refresh without slot", int'(any), 0);
      slot_open = 1;
      #1;
      check(rfr_fire == 1, "R5 first free slot", int'(rfr_fire), 1);
      check(rfr_row == 0, "R5 row", int'(rfr_row), 0);
      step();
      #1;
      check(rfr_fire == 0, "R5 one refresh only", int'(rfr_fire), 0);
      check(rfr_row == 1, "R3 row advanced", int'(rfr_row), 1);
   endtask

   // R6: refresh beats a waiting client request
   task automatic t_prio();
      do_reset();
      slot_open = 1; client_req = 1;
      for (int k = 0; k < IVL; k++) begin
         #1;
         if (k == IVL - 1 || k == 1)
            check(client_grant == 1, "R6 grant before due", int'(client_grant), 1);
         step();
      end
      #1;
      check(rfr_fire == 1, "R6 refresh fires", int'(rfr_fire), 1);
      check(client_grant == 0, "R6 grant suppressed", int'(client_grant), 0);
      step();
      #1;
      check(client_grant == 1, "R6 grant resumes", int'(client_grant), 1);
      txn_busy = 1;
      #1;
      check(client_grant == 0, "R6 no grant while busy", int'(client_grant), 0);
      txn_busy = 0; client_req = 0;
   endtask

   // R8: two expiries while blocked collapse into one refresh
   task automatic t_single();
      bit extra;
      do_reset();
      slot_open = 0;
      while (cyc < 2 * IVL + 4) step();
      slot_open = 1;
      #1;
      check(rfr_fire == 1, "R8 fire on unblock", int'(rfr_fire), 1);
      step();
      extra = 0;
      while (cyc < 3 * IVL) begin
         #1;
         if (rfr_fire) extra = 1;
         step();
      end
      check(!extra, "R8 no second refresh", int'(extra), 0);
      #1;
      check(rfr_fire == 1, "R8 next expiry", int'(rfr_fire), 1);
      check(rfr_row == 1, "R8 row", int'(rfr_row), 1);
   endtask

   // R9/R4: revisit gap under periodic interference
   task automatic t_revisit();
      int last [ROWS];
      int worst, nfire;
      bit busy_fire;
      foreach (last[i]) last[i] = -1;
      worst = 0; nfire = 0; busy_fire = 0;
      do_reset();
      for (int k = 0; k < 700; k++) begin
         txn_busy  = ((cyc % 25) < 10);
         slot_open = ((cyc % 2) == 0);
         #1;
         if (rfr_fire) begin
            nfire++;
            if (txn_busy) busy_fire = 1;
            if (last[rfr_row] >= 0 && cyc - last[rfr_row] > worst)
               worst = cyc - last[rfr_row];
            last[rfr_row] = cyc;
         end
         step();
      end
      txn_busy = 0; slot_open = 0;
      check(!busy_fire, "R4 quiet during transactions", int'(busy_fire), 0);
      check(worst > 0 && worst <= BOUND, "R9 revisit gap", worst, BOUND);
      check(nfire >= 40, "R9 refresh count", nfire, 40);
   endtask

   bit done = 0;

   initial begin
      t_reset();
      t_period();
      t_busy();
      t_prio();
      t_single();
      t_revisit();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule